// File: doc/BRIEF.md
# Per-Channel Vector Opcode Decoder

This block turns one test channel's vector opcode, an 8-bit ASCII character, into pin control for the cycle in which that vector runs. For each vector it produces a driver enable, a drive level and an expect mode. It then judges the expect mode against two comparator bits. One bit says the pin is above the high threshold. The other says it is below the low threshold. From this it produces an error bit and a recorded bit. The record-mode select picks what the recorded bit holds: the pin response, or the compare error.

Two opcodes carry no behaviour of their own. They refer back to the most recent plain opcode. One repeats it. The other applies its complement, in which drive level and expected level swap. The block keeps that plain opcode in a small register. Characters outside the known set act as the tristate code and set a sticky flag.

Vectors arrive on a valid/ready stream. A vector is accepted on a rising edge where `vec_valid` and `vec_ready` are both high. The comparator bits and the record-mode select are captured at that same edge. Results leave on a second valid/ready stream. A result stays on the outputs until the consumer raises `res_ready`. `vec_ready` is high whenever the result register is empty or is being drained in the same cycle, so back-pressure from the consumer reaches the producer without delay.

Top module: `vec_chan_decoder`

## Requirements
- R1: Characters '1' (0x31) and '0' (0x30) give `drive_en`=1, with `drive_val` equal to 1 and 0 respectively, and no expect, so `err`=0.
- R2: 'h' (0x68) drives 1 and expects high. 'l' (0x6C) drives 0 and expects low. '/' (0x2F) drives 0 and expects high. '\' (0x5C) drives 1 and expects low. Expect high fails when `cmp_hi`=0. Expect low fails when `cmp_lo`=0.
- R3: 'H' (0x48) expects high and 'L' (0x4C) expects low, both with `drive_en`=0. Whenever `drive_en`=0, `drive_val` is 0.
- R4: 'Z' (0x5A) gives `drive_en`=0, `drive_val`=0 and `err`=0 for any comparator input.
- R5: 'V' (0x56) and 'B' (0x42) leave the driver off. 'V' fails when both comparator bits are 0. 'B' fails when either comparator bit is 1.
- R6: 'R' (0x52) behaves as the most recent accepted plain character. 'R' and 'I' never change that stored character. After reset the stored character is 'Z'.
- R7: 'I' (0x49) behaves as the complement of the stored plain character. The complement pairs are 1/0, h/l, H/L, '/'/'\' and V/B, and Z is its own complement. Repeated 'I' codes give the same result each time.
- R8: With `rec_err_mode`=0, `rec_bit` equals the `cmp_hi` captured with the vector. With `rec_err_mode`=1, `rec_bit` equals `err`.
- R9: Any other character acts as 'Z' and becomes the stored plain character. It also sets `illegal_code`, which stays 1 until reset.
- R10: The result of an accepted vector appears on the next cycle with `res_valid`=1. It is held unchanged while `res_ready`=0. `vec_ready` is 1 exactly when `res_valid`=0 or `res_ready`=1.
- R11: During and after reset, `res_valid`, `drive_en`, `drive_val`, `err`, `rec_bit` and `illegal_code` are 0, and `vec_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vec_valid | input | 1 | A vector character is offered |
| vec_ready | output | 1 | The block can accept a vector this cycle |
| vec_char | input | CHAR_W | ASCII opcode for this channel |
| cmp_hi | input | 1 | Pin is above the high threshold |
| cmp_lo | input | 1 | Pin is below the low threshold |
| rec_err_mode | input | 1 | 0: record the response, 1: record the compare error |
| res_valid | output | 1 | A decoded result is present |
| res_ready | input | 1 | The consumer takes the result this cycle |
| drive_en | output | 1 | Driver enable |
| drive_val | output | 1 | Drive level |
| err | output | 1 | Compare error for this vector |
| rec_bit | output | 1 | Bit to store in record memory |
| illegal_code | output | 1 | Sticky flag: an unknown character was accepted |

## Verification
The stored plain opcode cannot be seen directly at the ports. A wrong value there shows up at the first later 'R' or 'I' code, in the result one cycle after that code is accepted. The drive level, the driver enable and the error pattern across the four comparator combinations then show which plain code was actually stored. A wrong decode or compare table entry shows in the very next result. Each plain code is therefore swept against every comparator pattern in both record modes, and each is then followed by a reference code. A result-register fault shows as values that change while `res_ready` is held low, or as a wrong `vec_ready` in the stalled cycle.

// File: rtl/vdec_pkg.sv
package vdec_pkg;

  typedef enum logic [3:0] {
    OP_D1   = 4'd0,
    OP_D0   = 4'd1,
    OP_DHEH = 4'd2,
    OP_DLEL = 4'd3,
    OP_EH   = 4'd4,
    OP_EL   = 4'd5,
    OP_OFF  = 4'd6,
    OP_DLEH = 4'd7,
    OP_DHEL = 4'd8,
    OP_EV   = 4'd9,
    OP_EI   = 4'd10
  } op_e;

  typedef enum logic [2:0] {
    EXP_NONE    = 3'd0,
    EXP_HI      = 3'd1,
    EXP_LO      = 3'd2,
    EXP_VALID   = 3'd3,
    EXP_INVALID = 3'd4
  } exp_e;

  typedef enum logic [1:0] {
    REF_PLAIN  = 2'd0,
    REF_REPEAT = 2'd1,
    REF_INVERT = 2'd2
  } ref_e;

  typedef struct packed {
    logic drv_en;
    logic drv_lvl;
    exp_e expect_mode;
  } pinctl_t;

  function automatic op_e op_invert(input op_e o);
    case (o)
      OP_D1:   return OP_D0;
      OP_D0:   return OP_D1;
      OP_DHEH: return OP_DLEL;
      OP_DLEL: return OP_DHEH;
      OP_EH:   return OP_EL;
      OP_EL:   return OP_EH;
      OP_DLEH: return OP_DHEL;
      OP_DHEL: return OP_DLEH;
      OP_EV:   return OP_EI;
      OP_EI:   return OP_EV;
      default: return OP_OFF;
    endcase
  endfunction

  function automatic pinctl_t op_decode(input op_e o);
    pinctl_t c;
    c = '{drv_en: 1'b0, drv_lvl: 1'b0, expect_mode: EXP_NONE};
    case (o)
      OP_D1:   c = '{drv_en: 1'b1, drv_lvl: 1'b1, expect_mode: EXP_NONE};
      OP_D0:   c = '{drv_en: 1'b1, drv_lvl: 1'b0, expect_mode: EXP_NONE};
      OP_DHEH: c = '{drv_en: 1'b1, drv_lvl: 1'b1, expect_mode: EXP_HI};
      OP_DLEL: c = '{drv_en: 1'b1, drv_lvl: 1'b0, expect_mode: EXP_LO};
      OP_EH:   c = '{drv_en: 1'b0, drv_lvl: 1'b0, expect_mode: EXP_HI};
      OP_EL:   c = '{drv_en: 1'b0, drv_lvl: 1'b0, expect_mode: EXP_LO};
      OP_DLEH: c = '{drv_en: 1'b1, drv_lvl: 1'b0, expect_mode: EXP_HI};
      OP_DHEL: c = '{drv_en: 1'b1, drv_lvl: 1'b1, expect_mode: EXP_LO};
      OP_EV:   c = '{drv_en: 1'b0, drv_lvl: 1'b0, expect_mode: EXP_VALID};
      OP_EI:   c = '{drv_en: 1'b0, drv_lvl: 1'b0, expect_mode: EXP_INVALID};
      default: c = '{drv_en: 1'b0, drv_lvl: 1'b0, expect_mode: EXP_NONE};
    endcase
    return c;
  endfunction

endpackage

// File: rtl/vdec_char_map.sv
module vdec_char_map
  import vdec_pkg::*;
#(
  parameter int CHAR_W = 8
) (
  input  logic [CHAR_W-1:0] ch,
  output op_e               op,
  output ref_e              kind,
  output logic              legal
);

  localparam logic [CHAR_W-1:0] K_ONE   = CHAR_W'(8'h31);
  localparam logic [CHAR_W-1:0] K_ZERO  = CHAR_W'(8'h30);
  localparam logic [CHAR_W-1:0] K_LC_H  = CHAR_W'(8'h68);
  localparam logic [CHAR_W-1:0] K_LC_L  = CHAR_W'(8'h6C);
  localparam logic [CHAR_W-1:0] K_UC_H  = CHAR_W'(8'h48);
  localparam logic [CHAR_W-1:0] K_UC_L  = CHAR_W'(8'h4C);
  localparam logic [CHAR_W-1:0] K_TRI   = CHAR_W'(8'h5A);
  localparam logic [CHAR_W-1:0] K_SLASH = CHAR_W'(8'h2F);
  localparam logic [CHAR_W-1:0] K_BSL   = CHAR_W'(8'h5C);
  localparam logic [CHAR_W-1:0] K_VAL   = CHAR_W'(8'h56);
  localparam logic [CHAR_W-1:0] K_INV   = CHAR_W'(8'h42);
  localparam logic [CHAR_W-1:0] K_RPT   = CHAR_W'(8'h52);
  localparam logic [CHAR_W-1:0] K_CMP   = CHAR_W'(8'h49);

  always_comb begin
    op    = OP_OFF;
    kind  = REF_PLAIN;
    legal = 1'b1;
    case (ch)
      K_ONE:   op = OP_D1;
      K_ZERO:  op = OP_D0;
      K_LC_H:  op = OP_DHEH;
      K_LC_L:  op = OP_DLEL;
      K_UC_H:  op = OP_EH;
      K_UC_L:  op = OP_EL;
      K_TRI:   op = OP_OFF;
      K_SLASH: op = OP_DLEH;
      K_BSL:   op = OP_DHEL;
      K_VAL:   op = OP_EV;
      K_INV:   op = OP_EI;
      K_RPT:   kind = REF_REPEAT;
      K_CMP:   kind = REF_INVERT;
      default: legal = 1'b0;
    endcase
  end

endmodule

// File: rtl/vdec_resolve.sv
module vdec_resolve
  import vdec_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic adv,
  input  op_e  op_in,
  input  ref_e kind,
  output op_e  op_eff
);

  op_e last_q;

  always_comb begin
    case (kind)
      REF_REPEAT: op_eff = last_q;
      REF_INVERT: op_eff = op_invert(last_q);
      default:    op_eff = op_in;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= OP_OFF;
    end else if (adv && kind == REF_PLAIN) begin
      last_q <= op_in;
    end
  end

endmodule

// File: rtl/vdec_compare.sv
module vdec_compare
  import vdec_pkg::*;
(
  input  op_e  op,
  input  logic cmp_hi,
  input  logic cmp_lo,
  input  logic rec_err_mode,
  output logic drv_en,
  output logic drv_lvl,
  output logic fail,
  output logic rec
);

  pinctl_t ctl;

  always_comb begin
    ctl     = op_decode(op);
    drv_en  = ctl.drv_en;
    drv_lvl = ctl.drv_lvl;
    case (ctl.expect_mode)
      EXP_HI:      fail = ~cmp_hi;
      EXP_LO:      fail = ~cmp_lo;
      EXP_VALID:   fail = ~(cmp_hi | cmp_lo);
      EXP_INVALID: fail = cmp_hi | cmp_lo;
      default:     fail = 1'b0;
    endcase
    rec = rec_err_mode ? fail : cmp_hi;
  end

endmodule

// File: rtl/vec_chan_decoder.sv
module vec_chan_decoder
  import vdec_pkg::*;
#(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vec_valid,
  output logic              vec_ready,
  input  logic [CHAR_W-1:0] vec_char,
  input  logic              cmp_hi,
  input  logic              cmp_lo,
  input  logic              rec_err_mode,
  output logic              res_valid,
  input  logic              res_ready,
  output logic              drive_en,
  output logic              drive_val,
  output logic              err,
  output logic              rec_bit,
  output logic              illegal_code
);

  op_e  map_op;
  ref_e map_kind;
  logic map_legal;
  op_e  eff_op;
  logic c_en, c_lvl, c_fail, c_rec;
  logic accept;

  assign vec_ready = ~res_valid | res_ready;
  assign accept    = vec_valid & vec_ready;

  vdec_char_map #(.CHAR_W(CHAR_W)) u_map (
    .ch    (vec_char),
    .op    (map_op),
    .kind  (map_kind),
    .legal (map_legal)
  );

  vdec_resolve u_res (
    .clk    (clk),
    .rst_n  (rst_n),
    .adv    (accept),
    .op_in  (map_op),
    .kind   (map_kind),
    .op_eff (eff_op)
  );

  vdec_compare u_cmp (
    .op           (eff_op),
    .cmp_hi       (cmp_hi),
    .cmp_lo       (cmp_lo),
    .rec_err_mode (rec_err_mode),
    .drv_en       (c_en),
    .drv_lvl      (c_lvl),
    .fail         (c_fail),
    .rec          (c_rec)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid    <= 1'b0;
      drive_en     <= 1'b0;
      drive_val    <= 1'b0;
      err          <= 1'b0;
      rec_bit      <= 1'b0;
      illegal_code <= 1'b0;
    end else begin
      if (accept) begin
        res_valid <= 1'b1;
        drive_en  <= c_en;
        drive_val <= c_lvl;
        err       <= c_fail;
        rec_bit   <= c_rec;
        if (!map_legal) illegal_code <= 1'b1;
      end else if (res_ready) begin
        res_valid <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/vdec_checker.sv
module vdec_checker #(
  parameter int CHAR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              vec_valid,
  input logic              vec_ready,
  input logic [CHAR_W-1:0] vec_char,
  input logic              cmp_hi,
  input logic              rec_err_mode,
  input logic              res_valid,
  input logic              res_ready,
  input logic              drive_en,
  input logic              drive_val,
  input logic              err,
  input logic              rec_bit,
  input logic              illegal_code
);

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(drive_en) && $stable(drive_val)
                                && $stable(err) && $stable(rec_bit));

  assert_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid && vec_ready |=> res_valid);

  assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_code |=> illegal_code);

  assert_off_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !drive_en |-> !drive_val);

  assert_resp_R8: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid && vec_ready && !rec_err_mode |=> rec_bit == $past(cmp_hi));

  assert_errmode_R8: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid && vec_ready && rec_err_mode |=> rec_bit == err);

  assert_tristate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid && vec_ready && vec_char == CHAR_W'(8'h5A) |=> !drive_en && !err);

endmodule

bind vec_chan_decoder vdec_checker u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .vec_valid    (vec_valid),
  .vec_ready    (vec_ready),
  .vec_char     (vec_char),
  .cmp_hi       (cmp_hi),
  .rec_err_mode (rec_err_mode),
  .res_valid    (res_valid),
  .res_ready    (res_ready),
  .drive_en     (drive_en),
  .drive_val    (drive_val),
  .err          (err),
  .rec_bit      (rec_bit),
  .illegal_code (illegal_code)
);

// File: tb/sim_vec_chan_decoder.sv
`timescale 1ns/1ps
module sim_vec_chan_decoder;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vec_valid = 1'b0;
  logic vec_ready;
  logic [7:0] vec_char = 8'h5A;
  logic cmp_hi = 1'b0, cmp_lo = 1'b0, rec_err_mode = 1'b0;
  logic res_valid;
  logic res_ready = 1'b1;
  logic drive_en, drive_val, err, rec_bit, illegal_code;

  always #2.5 clk = ~clk;

  vec_chan_decoder u0 (
    .clk(clk), .rst_n(rst_n), .vec_valid(vec_valid), .vec_ready(vec_ready),
    .vec_char(vec_char), .cmp_hi(cmp_hi), .cmp_lo(cmp_lo),
    .rec_err_mode(rec_err_mode), .res_valid(res_valid), .res_ready(res_ready),
    .drive_en(drive_en), .drive_val(drive_val), .err(err), .rec_bit(rec_bit),
    .illegal_code(illegal_code)
  );

  typedef struct {
    logic [3:0] v;
    string      tag;
  } item_t;

  item_t exp_q[$];
  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] m_last = "Z";
  int ready_mode = 0;
  logic [7:0] lfsr = 8'h5B;
  logic done = 1'b0;

  task automatic check(input string tag, input logic [3:0] got, input logic [3:0] want);
    n_chk++;
    if (got !== want) begin
      n_bad++;
      $display("FAIL %s got=%b expected=%b", tag, got, want);
    end
  endtask

  function automatic logic is_plain(input logic [7:0] c);
    case (c)
      "1", "0", "h", "l", "H", "L", "Z", "/", "\\", "V", "B": return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [7:0] compl(input logic [7:0] c);
    case (c)
      "1": return "0";   "0": return "1";
      "h": return "l";   "l": return "h";
      "H": return "L";   "L": return "H";
      "/": return "\\";  "\\": return "/";
      "V": return "B";   "B": return "V";
      default: return "Z";
    endcase
  endfunction

  function automatic string tag_of(input logic [7:0] c);
    case (c)
      "1", "0": return "R1";
      "h", "l", "/", "\\": return "R2";
      "H", "L": return "R3";
      "Z": return "R4";
      "V", "B": return "R5";
      "R": return "R6";
      "I": return "R7";
      default: return "R9";
    endcase
  endfunction

  // expected {drive_en, drive_val, err, rec_bit}; updates the bench's own last code
  function automatic logic [3:0] model(input logic [7:0] c, input logic hi, input logic lo,
                                       input logic mode);
    logic [7:0] e;
    logic de, dv, f;
    if (c == "R") e = m_last;
    else if (c == "I") e = compl(m_last);
    else begin
      e = is_plain(c) ? c : "Z";
      m_last = e;
    end
    de = 1'b0; dv = 1'b0; f = 1'b0;
    case (e)
      "1": begin de = 1; dv = 1; end
      "0": begin de = 1; dv = 0; end
      "h": begin de = 1; dv = 1; f = !hi; end
      "l": begin de = 1; dv = 0; f = !lo; end
      "/": begin de = 1; dv = 0; f = !hi; end
      "\\": begin de = 1; dv = 1; f = !lo; end
      "H": f = !hi;
      "L": f = !lo;
      "V": f = !(hi || lo);
      "B": f = hi || lo;
      default: ;
    endcase
    return {de, dv, f, mode ? f : hi};
  endfunction

  task automatic send(input logic [7:0] c, input logic hi, input logic lo, input logic mode);
    item_t it;
    vec_char = c; cmp_hi = hi; cmp_lo = lo; rec_err_mode = mode; vec_valid = 1'b1;
    while (1) begin
      #1;
      if (vec_ready) break;
      @(negedge clk);
    end
    it.v = model(c, hi, lo, mode);
    it.tag = tag_of(c);
    exp_q.push_back(it);
    @(negedge clk);
    vec_valid = 1'b0;
  endtask

  task automatic send_all(input logic [7:0] c);
    for (int k = 0; k < 8; k++) send(c, k[0], k[1], k[2]);
  endtask

  task automatic drain();
    while (exp_q.size() != 0 || res_valid) @(negedge clk);
  endtask

  // back-pressure pattern
  always @(negedge clk) begin
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    if (ready_mode == 1) res_ready = lfsr[0];
    else if (ready_mode == 2) res_ready = 1'b0;
    else res_ready = 1'b1;
  end

  // monitor: pops the scoreboard on every output transfer
  always begin
    @(negedge clk);
    #1;
    if (rst_n && res_valid && res_ready) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_bad++;
        $display("FAIL R10 got=unexpected result expected=none");
      end else begin
        item_t it;
        it = exp_q.pop_front();
        check(it.tag, {drive_en, drive_val, err, rec_bit}, it.v);
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog got=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [3:0] held;
    logic [7:0] plains[11];
    plains = '{"1", "0", "h", "l", "H", "L", "Z", "/", "\\", "V", "B"};
    repeat (3) @(negedge clk);
    #1;
    // R11: reset state
    check("R11", {res_valid, drive_en, drive_val, err}, 4'b0000);
    check("R11", {rec_bit, illegal_code, vec_ready, 1'b0}, 4'b0010);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    check("R11", {res_valid, illegal_code, vec_ready, drive_en}, 4'b0010);

    // R6: reference code straight after reset repeats 'Z'
    send("R", 1, 1, 1);
    send("I", 1, 0, 1);
    // R1 R2 R3 R4 R5 R8: every plain code, all comparator patterns, both record modes
    foreach (plains[i]) send_all(plains[i]);
    // R6 R7: each plain code followed by repeat and by repeated invert
    foreach (plains[i]) begin
      send(plains[i], 0, 0, 1);
      send_all("R");
      send_all("I");
      send("I", 1, 0, 1);
    end
    drain();

    // R10: random back-pressure across a mixed stream
    ready_mode = 1;
    for (int n = 0; n < 200; n++) begin
      logic [7:0] c;
      c = (n % 5 == 3) ? "R" : (n % 7 == 2) ? "I" : plains[n % 11];
      send(c, n[1], n[2], n[0]);
    end
    ready_mode = 0;
    drain();

    // R10: explicit stall, result held and input blocked
    ready_mode = 2;
    @(negedge clk);
    send("h", 1, 0, 0);
    #1;
    check("R10", {res_valid, vec_ready, 2'b00}, 4'b1000);
    held = {drive_en, drive_val, err, rec_bit};
    repeat (3) begin
      @(negedge clk);
      #1;
      check("R10", {drive_en, drive_val, err, rec_bit}, held);
    end
    ready_mode = 0;
    drain();

    // R9: unknown character acts as 'Z', becomes the stored code, flag sticks
    check("R9", {illegal_code, 3'b000}, 4'b0000);
    send("h", 1, 1, 1);
    send("x", 1, 0, 1);
    send("R", 0, 1, 1);
    send("I", 1, 1, 0);
    send("1", 0, 0, 1);
    drain();
    #1;
    check("R9", {illegal_code, 3'b000}, 4'b1000);
    send(8'h00, 0, 0, 0);
    send(8'hFF, 1, 1, 1);
    drain();
    #1;
    check("R9", {illegal_code, 3'b000}, 4'b1000);

    // R11: a second reset clears the flag and the stored code
    rst_n = 1'b0;
    m_last = "Z";
    @(negedge clk);
    #1;
    check("R11", {illegal_code, res_valid, vec_ready, 1'b0}, 4'b0010);
    rst_n = 1'b1;
    @(negedge clk);
    send("R", 1, 1, 1);
    send("I", 0, 0, 0);
    drain();

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule